// File: doc/BRIEF.md
# Loadable Synchronous Binary Counter Stage with Lookahead Carry

This block is one stage of a synchronous binary counter. In each clock cycle it does one of three things: it loads a parallel data word, it adds one to the stored value, or it keeps the stored value. A load request always wins over a count request. The increment path does not use a ripple chain. Instead, each bit has its own AND term that looks at the enable and all of the lower stored bits, so every toggle enable has the same logic depth.

The stage has a combinational carry output. This output goes high when counting is enabled, no load is requested, and every stored bit is 1. To build a wider counter, connect the carry of one stage to the count input of the next stage and share the load request across the stages. Two stages connected this way form an 8-bit counter. The stage width is a parameter. Reset is synchronous and active-high.

Top module: `lsc_stage`

## Requirements
- R1: When `rst` is 1 at a rising edge, `cnt_q` becomes all zeros on that edge. Right after reset, `carry_o` is 0.
- R2: When `load_i` is 1 at a rising edge, `cnt_q` takes the value of `data_i` on that edge, whatever the value of `count_i`.
- R3: When `load_i` is 0 and `count_i` is 1, `cnt_q` increases by one (modulo 2^WIDTH) on the rising edge. Bit i toggles only when the enable is active and all bits below i are 1.
- R4: When `load_i` and `count_i` are both 0, `cnt_q` keeps its value, whatever the value of `data_i`.
- R5: `carry_o` is 1 exactly when `count_i` is 1, `load_i` is 0 and `cnt_q` is all ones. It is 0 while `load_i` is 1.
- R6: Counting from all ones gives all zeros on the same edge at which `carry_o` is high.
- R7: Reset takes priority over a load or count request on the same edge.
- R8: Two stages connected carry-to-count, with a shared load and reset, form a counter of twice the width. The upper stage advances only on edges where the lower carry is high, and the pair wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous reset, active-high |
| load_i | input | 1 | Parallel load request; wins over counting |
| count_i | input | 1 | Count enable; in a cascade, driven by the previous carry |
| data_i | input | WIDTH | Value to load |
| cnt_q | output | WIDTH | Registered count |
| carry_o | output | 1 | Combinational carry-out for the next stage |

## Verification
The assertions check the following on every cycle:
- the load, increment and hold transitions of the register;
- reset clearing the count;
- a high carry being followed by a zero count;
- the toggle enables from the lookahead gating forming a nested thermometer pattern.

Some behaviour can only be shown by the bench's scenarios:
- that a load request blocks the carry, even when the register is all ones;
- that a data word presented during hold is ignored;
- that reset overrides a load on the same edge;
- that two cascaded stages behave as one 8-bit counter across the 255 to 0 wrap.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_INC  = 2'd1,
    MODE_LOAD = 2'd2
  } lsc_mode_e;
endpackage

// File: rtl/lsc_mode_dec.sv
module lsc_mode_dec
  import lsc_pkg::*;
(
  input  logic      load_i,
  input  logic      count_i,
  output lsc_mode_e mode_o
);
  // Load wins; count only applies when no load is requested.
  always_comb begin
    if (load_i)       mode_o = MODE_LOAD;
    else if (count_i) mode_o = MODE_INC;
    else              mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/lsc_lookahead.sv
module lsc_lookahead #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] tgl_o,
  output logic             tc_o
);
  // Each bit gets its own wide AND of the enable and all lower bits (no ripple).
  for (genvar i = 0; i < WIDTH; i++) begin : g_term
    if (i == 0) begin : g_lsb
      assign tgl_o[i] = en_i;
    end else begin : g_upper
      assign tgl_o[i] = en_i & (&q_i[i-1:0]);
    end
  end

  assign tc_o = en_i & (&q_i);

  // R3: a higher toggle enable implies every lower one (nested gating).
  for (genvar k = 1; k < WIDTH; k++) begin : g_chk
    assert_toggle_nest_R3 : assert property (@(posedge clk) disable iff (rst)
      tgl_o[k] |-> tgl_o[k-1]);
  end
endmodule

// File: rtl/lsc_stage.sv
module lsc_stage
  import lsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             count_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] cnt_q,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  lsc_mode_e        mode;
  logic [WIDTH-1:0] tgl;
  logic [WIDTH-1:0] nxt;
  logic             inc_en;

  lsc_mode_dec u_dec (
    .load_i (load_i),
    .count_i(count_i),
    .mode_o (mode)
  );

  assign inc_en = (mode == MODE_INC);

  lsc_lookahead #(.WIDTH(WIDTH)) u_la (
    .clk  (clk),
    .rst  (rst),
    .en_i (inc_en),
    .q_i  (cnt_q),
    .tgl_o(tgl),
    .tc_o (carry_o)
  );

  always_comb begin
    case (mode)
      MODE_LOAD: nxt = data_i;
      MODE_INC:  nxt = cnt_q ^ tgl;
      default:   nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt;
  end

  assert_reset_clear_R1 : assert property (@(posedge clk)
    rst |=> cnt_q == '0);
  assert_load_take_R2 : assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_q == $past(data_i));
  assert_increment_R3 : assert property (@(posedge clk) disable iff (rst)
    (!load_i && count_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_hold_R4 : assert property (@(posedge clk) disable iff (rst)
    (!load_i && !count_i) |=> $stable(cnt_q));
  assert_carry_gated_R5 : assert property (@(posedge clk) disable iff (rst)
    carry_o |-> (count_i && !load_i && cnt_q == ALL_ONES));
  assert_wrap_R6 : assert property (@(posedge clk) disable iff (rst)
    carry_o |=> cnt_q == '0);
endmodule

// File: tb/lsc_stage_test.sv
module lsc_stage_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld = 1'b0;
  logic       en = 1'b0;
  logic [3:0] din_lo = '0;
  logic [3:0] din_hi = '0;
  logic [3:0] q_lo, q_hi;
  logic       co_lo, co_hi;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lsc_stage #(.WIDTH(4)) uut (
    .clk(clk), .rst(rst), .load_i(ld), .count_i(en),
    .data_i(din_lo), .cnt_q(q_lo), .carry_o(co_lo)
  );
  lsc_stage #(.WIDTH(4)) uut_hi (
    .clk(clk), .rst(rst), .load_i(ld), .count_i(co_lo),
    .data_i(din_hi), .cnt_q(q_hi), .carry_o(co_hi)
  );

  // {load, count, data, expected q after edge}
  localparam logic [9:0] VEC [0:9] = '{
    {1'b1, 1'b0, 4'hE, 4'hE},
    {1'b0, 1'b0, 4'h0, 4'hE},
    {1'b0, 1'b1, 4'h0, 4'hF},
    {1'b0, 1'b1, 4'h0, 4'h0},
    {1'b1, 1'b1, 4'h5, 4'h5},
    {1'b0, 1'b1, 4'h0, 4'h6},
    {1'b0, 1'b0, 4'hA, 4'h6},
    {1'b1, 1'b0, 4'hF, 4'hF},
    {1'b0, 1'b0, 4'h0, 4'hF},
    {1'b1, 1'b1, 4'h3, 4'h3}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic l, input logic c);
    if (l) return "R2";
    if (c) return "R3";
    return "R4";
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    logic [7:0] m8;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset q", int'(q_lo), 0);
    check("R1 reset carry", int'(co_lo), 0);

    prev = 4'h0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ld = VEC[i][9]; en = VEC[i][8]; din_lo = VEC[i][7:4];
      #1;
      check((ld ? "R5 carry blocked by load" : (prev == 4'hF && en) ? "R6 carry at wrap" : "R5 carry"),
            int'(co_lo), int'(en && !ld && prev == 4'hF));
      @(posedge clk); #1;
      check(mode_tag(VEC[i][9], VEC[i][8]), int'(q_lo), int'(VEC[i][3:0]));
      prev = VEC[i][3:0];
    end

    // R7: reset beats load
    @(negedge clk);
    rst = 1'b1; ld = 1'b1; en = 1'b1; din_lo = 4'h9;
    @(posedge clk); #1;
    check("R7 reset over load", int'(q_lo), 0);
    @(negedge clk);
    rst = 1'b0; ld = 1'b0; en = 1'b0;

    // R8: cascade from 0, through the 255 wrap
    m8 = 8'h00;
    for (int n = 0; n < 260; n++) begin
      @(negedge clk);
      en = 1'b1;
      @(posedge clk); #1;
      m8 = m8 + 8'd1;
      check("R8 cascade count", int'({q_hi, q_lo}), int'(m8));
    end

    // R8: load both stages, then cross 255 -> 0
    @(negedge clk);
    ld = 1'b1; en = 1'b0; din_hi = 4'hF; din_lo = 4'hD;
    @(posedge clk); #1;
    m8 = 8'hFD;
    check("R8 cascade load", int'({q_hi, q_lo}), int'(m8));
    @(negedge clk);
    ld = 1'b0;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      en = 1'b1;
      #1;
      check("R8 lower carry", int'(co_lo), int'(q_lo == 4'hF));
      @(posedge clk); #1;
      m8 = m8 + 8'd1;
      check("R8 cascade wrap", int'({q_hi, q_lo}), int'(m8));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule